// File: doc/BRIEF.md
# Single-Clock FIFO with Read Rewind and Half-Occupancy Flag

This block is a single-clock first-in/first-out buffer for 9-bit words with a parameterised number of entries. A producer pushes words with a write enable and a consumer pops them with a read enable. The two sides may act in the same cycle. Three active-low status outputs report an empty buffer, a full buffer and a buffer holding more than half of its entries. The ninth data bit is carried through untouched, so it can serve as a parity or marker bit for the user.

A rewind request moves the read position back to the first storage location and leaves the write position where it is. The consumer can then read again everything written since reset, which is useful for resending a short packet after an error. Read data comes out of a register one cycle after the read is accepted, together with a valid strobe. The strobe is low in every cycle that has no accepted read.

Top module: `rewind_fifo`

## Requirements
- R1: All 9 bits of a written word, including bit 8, are returned unchanged by the read that pops it.
- R2: Reset is synchronous and active low. After a clock edge with `rst_n` low, both positions are at location zero, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `rd_valid` is 0. Enables held during reset store and return nothing.
- R3: When `rt_req` is 1 while `wr_en` and `rd_en` are both 0, the read position returns to location zero and the write position is kept. Occupancy then becomes the write position, or DEPTH when the write position has wrapped back to zero after DEPTH writes. The flags follow the new occupancy after that edge.
- R4: A rewind request made in a cycle where `wr_en` or `rd_en` is 1 is ignored. That cycle's read and write act normally.
- R5: A write while full (with no accepted read in the same cycle) is dropped and the write position holds. A read while empty is dropped, the read position holds and `rd_valid` stays 0.
- R6: `half_n` goes to 0 after the write that raises occupancy above DEPTH/2. It returns to 1 after the read that brings occupancy to DEPTH/2 or less.
- R7: `full_n` is 0 exactly when occupancy equals DEPTH, and `empty_n` is 0 exactly when occupancy is zero. Both reflect the occupancy after the most recent clock edge.
- R8: A read accepted at a clock edge puts the oldest word on `rd_data` and drives `rd_valid` to 1 after that edge. After an edge with no accepted read, `rd_valid` is 0.
- R9: A read and a write in the same cycle are both accepted when not blocked, and occupancy stays the same. While full, the read is performed and the write is also accepted. While empty, only the write is accepted.
- R10: Starting from reset with no reads, `full_n` goes to 0 after exactly DEPTH accepted writes and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request for this cycle |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read request for this cycle |
| rt_req | input | 1 | Rewind the read position to location zero |
| rd_data | output | 9 | Word popped by the last accepted read |
| rd_valid | output | 1 | High for the cycle after an accepted read |
| empty_n | output | 1 | Low when the buffer holds no words |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| half_n | output | 1 | Low when the buffer holds more than DEPTH/2 words |

## Verification
The assertions assume that `rst_n` is low at the first clock edge. They also assume that a rewind is requested only when the words from location zero up to the write position are still the ones that should be read again, meaning fewer than DEPTH writes, or exactly DEPTH, since reset. The bench first applies reset and drives every input at the falling edge. Each rewind it issues follows at most DEPTH writes from a fresh reset, and its ignored-rewind cases always pair the request with an active enable.

// File: rtl/rewind_fifo_pkg.sv
// Package: shared word width and word type for the rewind FIFO.
// Assumes: nothing; constants only.
package rewind_fifo_pkg;
    localparam int WORD_W = 9;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rewind_fifo_ptrs.sv
// Position and occupancy control for the rewind FIFO.
// Decides which requests are accepted, advances the read and write
// positions, tracks occupancy in a counter one bit wider than the address,
// and handles the rewind of the read position.
// Assumes: DEPTH >= 2; rewind is meaningful only when at most DEPTH writes
// have happened since reset.
module rewind_fifo_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          rt_req,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          wr_acc,
    output logic          rd_acc,
    output logic [CW-1:0] occ
);
    localparam logic [CW-1:0] OCC_FULL = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);

    logic          rt_acc;
    logic          wrapped;
    logic [CW-1:0] rt_occ;

    // Acceptance: reads need data, writes need room or a same-cycle read.
    always_comb begin
        rd_acc = rd_en && (occ != '0);
        wr_acc = wr_en && ((occ != OCC_FULL) || rd_acc);
        rt_acc = rt_req && !wr_en && !rd_en;
    end

    // Occupancy after a rewind: words from location zero up to the write position.
    always_comb begin
        if (wrapped && (wr_ptr == '0)) begin
            rt_occ = OCC_FULL;
        end else begin
            rt_occ = CW'(wr_ptr);
        end
    end

    // Write position and the wrap marker used by rewind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
        end else if (wr_acc) begin
            if (wr_ptr == LAST_LOC) begin
                wr_ptr  <= '0;
                wrapped <= 1'b1;
            end else begin
                wr_ptr <= wr_ptr + AW'(1);
            end
        end
    end

    // Read position: rewound by an accepted request, else advanced on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (rt_acc) begin
            rd_ptr <= '0;
        end else if (rd_acc) begin
            rd_ptr <= (rd_ptr == LAST_LOC) ? '0 : rd_ptr + AW'(1);
        end
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else if (rt_acc) begin
            occ <= rt_occ;
        end else if (wr_acc && !rd_acc) begin
            occ <= occ + CW'(1);
        end else if (rd_acc && !wr_acc) begin
            occ <= occ - CW'(1);
        end
    end

    // R5: occupancy never exceeds the number of entries.
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_FULL);

    // R5: a lone write while full leaves the write position alone.
    a_r5_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && occ == OCC_FULL) |=> $stable(wr_ptr));

    // R5: a read while empty leaves the read position alone.
    a_r5_empty_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && occ == '0) |=> $stable(rd_ptr));

    // R3: an accepted rewind zeroes the read position and keeps the write position.
    a_r3_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_req && !wr_en && !rd_en) |=> (rd_ptr == '0) && $stable(wr_ptr));
endmodule

// File: rtl/rewind_fifo_store.sv
// Storage array and registered read port for the rewind FIFO.
// Writes the accepted word at the write position. On an accepted read it
// registers the word at the read position and raises the valid strobe for
// one cycle.
// Assumes: accept strobes come from the position controller and are
// already gated by the full and empty conditions.
module rewind_fifo_store
    import rewind_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_acc,
    input  logic [AW-1:0] wr_ptr,
    input  word_t         wr_data,
    input  logic          rd_acc,
    input  logic [AW-1:0] rd_ptr,
    output word_t         rd_data,
    output logic          rd_valid
);
    word_t mem [DEPTH];

    // Array write; no reset on storage.
    always_ff @(posedge clk) begin
        if (wr_acc) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Registered read word and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_acc;
            if (rd_acc) begin
                rd_data <= mem[rd_ptr];
            end
        end
    end

    // R8: an accepted read yields a valid word next cycle.
    a_r8_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rd_valid);

    // R8: no accepted read means no valid strobe next cycle.
    a_r8_quiet_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !rd_valid);
endmodule

// File: rtl/rewind_fifo_flags.sv
// Status flag decode for the rewind FIFO.
// Produces active-low empty, full and more-than-half flags from the
// registered occupancy, so every flag changes only after a clock edge.
// Assumes: occupancy lies between zero and DEPTH.
module rewind_fifo_flags #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] occ,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);
    localparam logic [CW-1:0] OCC_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] OCC_HALF = CW'(DEPTH / 2);

    // Flag decode against the fixed thresholds.
    always_comb begin
        empty_n = (occ != '0);
        full_n  = (occ != OCC_FULL);
        half_n  = (occ <= OCC_HALF);
    end

    // R7: empty and full never hold together.
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n));

    // R6: more than half implies not empty.
    a_r6_half_implies_data: assert property (@(posedge clk) disable iff (!rst_n)
        !half_n |-> empty_n);

    // R2: the first cycle out of reset shows the reset flag state.
    a_r2_reset_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!empty_n && full_n && half_n));
endmodule

// File: rtl/rewind_fifo.sv
// Top of the rewind FIFO: a single-clock 9-bit buffer with active-low
// empty, full and half flags and a read-position rewind.
// Assumes: one clock domain; synchronous active-low reset applied at start.
module rewind_fifo
    import rewind_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic                rt_req,
    output logic [WORD_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic                empty_n,
    output logic                full_n,
    output logic                half_n
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          wr_acc;
    logic          rd_acc;
    logic [CW-1:0] occ;

    rewind_fifo_ptrs #(.DEPTH(DEPTH)) i_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .rt_req (rt_req),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .wr_acc (wr_acc),
        .rd_acc (rd_acc),
        .occ    (occ)
    );

    rewind_fifo_store #(.DEPTH(DEPTH)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_acc   (wr_acc),
        .wr_ptr   (wr_ptr),
        .wr_data  (wr_data),
        .rd_acc   (rd_acc),
        .rd_ptr   (rd_ptr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    rewind_fifo_flags #(.DEPTH(DEPTH)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .occ     (occ),
        .empty_n (empty_n),
        .full_n  (full_n),
        .half_n  (half_n)
    );
endmodule

// File: tb/test_rewind_fifo.sv
module test_rewind_fifo;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       rt_req = 1'b0;
    logic [8:0] rd_data;
    logic       rd_valid;
    logic       empty_n;
    logic       full_n;
    logic       half_n;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rewind_fifo #(.DEPTH(DEPTH)) i_rewind_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rt_req(rt_req), .rd_data(rd_data),
        .rd_valid(rd_valid), .empty_n(empty_n), .full_n(full_n),
        .half_n(half_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, return just after the rising edge.
    task automatic cyc(input logic we, input logic [8:0] d, input logic re, input logic rt);
        @(negedge clk);
        wr_en = we; wr_data = d; rd_en = re; rt_req = rt;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rt_req = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rd_expect(input string tag, input int exp);
        cyc(1'b0, '0, 1'b1, 1'b0);
        chk({tag, " valid"}, int'(rd_valid), 1);
        chk({tag, " data"}, int'(rd_data), exp);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R2 empty_n after reset", int'(empty_n), 0);
        chk("R2 full_n after reset", int'(full_n), 1);
        chk("R2 half_n after reset", int'(half_n), 1);
        chk("R2 rd_valid after reset", int'(rd_valid), 0);
        // write held during reset must not store
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b1; wr_data = 9'h1F0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0;
        @(posedge clk);
        #1;
        chk("R2 write in reset ignored", int'(empty_n), 0);
        cyc(1'b0, '0, 1'b1, 1'b0);
        chk("R2 no data after reset write", int'(rd_valid), 0);
    endtask

    task automatic t_fill_drain();
        do_reset();
        for (int i = 1; i <= DEPTH; i++) begin
            cyc(1'b1, 9'(i), 1'b0, 1'b0);
            if (i == DEPTH / 2) chk("R6 half_n at exactly half", int'(half_n), 1);
            if (i == DEPTH / 2 + 1) chk("R6 half_n above half", int'(half_n), 0);
            if (i == DEPTH - 1) chk("R10 not full one short", int'(full_n), 1);
            if (i == DEPTH) chk("R10 full after DEPTH writes", int'(full_n), 0);
        end
        cyc(1'b1, 9'h0EE, 1'b0, 1'b0);
        chk("R5 full holds after extra write", int'(full_n), 0);
        cyc(1'b0, '0, 1'b0, 1'b0);
        chk("R8 idle rd_valid low", int'(rd_valid), 0);
        for (int i = 1; i <= DEPTH; i++) begin
            rd_expect("R5/R8 drain order", i);
            if (i == 1) chk("R7 full_n clears after read", int'(full_n), 1);
            if (i == DEPTH / 2 - 1) chk("R6 half held above half", int'(half_n), 0);
            if (i == DEPTH / 2) chk("R6 half clears at half", int'(half_n), 1);
            if (i == DEPTH - 1) chk("R7 not empty one left", int'(empty_n), 1);
        end
        chk("R7 empty after last read", int'(empty_n), 0);
        cyc(1'b0, '0, 1'b1, 1'b0);
        chk("R5 read on empty gives no data", int'(rd_valid), 0);
        chk("R5 still empty", int'(empty_n), 0);
    endtask

    task automatic t_simul();
        do_reset();
        cyc(1'b1, 9'h155, 1'b0, 1'b0);
        cyc(1'b1, 9'h0AB, 1'b1, 1'b0);
        chk("R9 rw read word", int'(rd_data), 'h155);
        chk("R1 bit 8 kept", int'(rd_data[8]), 1);
        chk("R9 rw occupancy kept", int'(empty_n), 1);
        rd_expect("R9 rw second word", 'h0AB);
        chk("R9 empty after", int'(empty_n), 0);
        // read+write while empty: only the write
        cyc(1'b1, 9'h033, 1'b1, 1'b0);
        chk("R9 empty rw no read", int'(rd_valid), 0);
        chk("R9 empty rw write taken", int'(empty_n), 1);
        rd_expect("R9 empty rw word", 'h033);
        // full with simultaneous read and write
        do_reset();
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 9'(9'h100 + i), 1'b0, 1'b0);
        cyc(1'b1, 9'h1AA, 1'b1, 1'b0);
        chk("R9 full rw read", int'(rd_data), 'h100);
        chk("R9 full rw stays full", int'(full_n), 0);
        for (int i = 1; i < DEPTH; i++) rd_expect("R9 full rw order", 'h100 + i);
        rd_expect("R1/R9 full rw written word", 'h1AA);
        chk("R9 empty at end", int'(empty_n), 0);
    endtask

    task automatic t_rewind();
        do_reset();
        for (int i = 0; i < 5; i++) cyc(1'b1, 9'(9'h010 + i), 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) rd_expect("R3 pre-rewind read", 'h010 + i);
        cyc(1'b0, '0, 1'b0, 1'b1);
        chk("R3 rewind no data strobe", int'(rd_valid), 0);
        for (int i = 0; i < 5; i++) rd_expect("R3 reread", 'h010 + i);
        chk("R3 empty after reread", int'(empty_n), 0);
        // rewind restores above-half occupancy
        do_reset();
        for (int i = 0; i < 10; i++) cyc(1'b1, 9'(i), 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) rd_expect("R3 drain ten", i);
        chk("R3 half clear before rewind", int'(half_n), 1);
        cyc(1'b0, '0, 1'b0, 1'b1);
        chk("R3/R6 half after rewind", int'(half_n), 0);
        chk("R3 not empty after rewind", int'(empty_n), 1);
        // rewind after exactly DEPTH writes restores full
        do_reset();
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 9'(9'h080 + i), 1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) rd_expect("R3 drain full", 'h080 + i);
        cyc(1'b0, '0, 1'b0, 1'b1);
        chk("R3 full after wrapped rewind", int'(full_n), 0);
        rd_expect("R3 wrapped reread first", 'h080);
    endtask

    task automatic t_rewind_ignored();
        do_reset();
        for (int i = 0; i < 4; i++) cyc(1'b1, 9'(9'h020 + i), 1'b0, 1'b0);
        rd_expect("R4 first read", 'h020);
        cyc(1'b0, '0, 1'b1, 1'b1);
        chk("R4 rewind with read: read done", int'(rd_data), 'h021);
        rd_expect("R4 no rewind with read", 'h022);
        cyc(1'b1, 9'h024, 1'b0, 1'b1);
        rd_expect("R4 no rewind with write", 'h023);
        rd_expect("R4 write taken with rewind", 'h024);
        chk("R4 empty at end", int'(empty_n), 0);
    endtask

    initial begin
        t_reset();
        t_fill_drain();
        t_simul();
        t_rewind();
        t_rewind_ignored();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule